// File: doc/BRIEF.md
# Register Exchange and Quick-Load Unit

This unit holds the sixteen 32-bit registers of a small processor core. There are eight data registers and eight address registers. The unit executes three register-only operations taken from a 16-bit instruction word:

- **Exchange** swaps two registers at one clock edge.
- **Quick load** places a sign-extended 8-bit constant from the instruction into a data register and updates the condition flags.
- **Address load** copies an effective address, already computed outside the unit, into an address register.

Each completed operation reports a fixed cycle cost for the core's timing accounting.

A small state machine controls the unit. In state `S_IDLE` it raises `ready` and samples `instr_vld`. On an accepted word, the transition `IDLE->EXCH`, `IDLE->QUICK`, `IDLE->ADDR` or `IDLE->ILL` is taken according to the decoded class. An unrecognised word takes `IDLE->IDLE` and is dropped. Each of the four working states performs its update and returns to `S_IDLE` on the next edge (`EXCH->IDLE`, `QUICK->IDLE`, `ADDR->IDLE`, `ILL->IDLE`). At that same edge, `done` or `illegal` pulses for one cycle. Two combinational read ports let the surrounding core observe any data or address register.

Top module: `regxq_unit`

## Requirements
- R1: After reset, all sixteen registers read 0, all four flags are 0, `ready` is 1, and `done`, `illegal` and `cyc_cost` are 0.
- R2: A word is accepted at a rising edge where `instr_vld` and `ready` are both 1. An accepted recognised word drives `ready` to 0 for exactly one cycle. Its results, `done` or `illegal`, and `cyc_cost` all appear after the following edge. `instr_vld` is ignored while `ready` is 0. `cyc_cost` holds its value until the next `done` or `illegal`.
- R3: Quick load is encoded with bits 15:12 = 0111 and bit 8 = 0. It writes bits 7:0, sign-extended to 32 bits, into data register bits 11:9 and reports cost 4.
- R4: Quick load sets `flag_n` to bit 31 of the result and sets `flag_z` when the result is zero. It clears `flag_v` and `flag_c`.
- R5: Exchange is encoded with bits 15:12 = 1100 and bit 8 = 1, and the pairing is chosen by bits 7:3:
  - 01000 swaps data registers [11:9] and [2:0].
  - 01001 swaps address registers [11:9] and [2:0].
  - 10001 swaps data register [11:9] with address register [2:0].
  
  It reports cost 6.
- R6: Both registers of an exchange update at the same edge, so swapping a register with itself leaves its value unchanged.
- R7: Address load is encoded with bits 15:12 = 0100 and bits 8:6 = 111. It writes `ea_in` into address register bits 11:9. The cost depends on bits 5:3 (mode) and 2:0 (sub):
  - mode 010 costs 4.
  - mode 101 costs 8.
  - mode 110 costs 12.
  - mode 111 costs 8 for sub 000 and sub 010, and 12 for sub 001 and sub 011.
- R8: An exchange with any other bits 7:3 pattern, or an address load with any other mode/sub, changes no register and no flag. It pulses `illegal` for one cycle, leaves `done` at 0 and sets `cyc_cost` to 0.
- R9: Exchange and address load leave all four flags unchanged.
- R10: Any other instruction word is dropped: `ready` stays 1, `done` and `illegal` stay 0, and no register, flag or `cyc_cost` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_vld | input | 1 | Instruction word valid |
| instr | input | 16 | Instruction word |
| ea_in | input | 32 | Precomputed effective address for address load |
| ready | output | 1 | Unit idle and able to accept a word |
| rd_sel_d | input | 3 | Data register read select |
| rd_data_d | output | 32 | Selected data register value |
| rd_sel_a | input | 3 | Address register read select |
| rd_data_a | output | 32 | Selected address register value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| cyc_cost | output | 4 | Cycle cost of the last completed or rejected operation |
| done | output | 1 | One-cycle pulse when an operation completes |
| illegal | output | 1 | One-cycle pulse when an operation is rejected |

## Verification
The bench builds the unit with its default values: 32-bit registers, eight registers per bank, and a 4-bit cost field. With these values, every register index in the instruction fields is reachable, so every data and address register can be written and read back. Sign extension is exercised at 0x7F, 0x80, 0xFF and 0x00. Arbitrary 32-bit patterns reach the data bank by an address load followed by a mixed exchange. This makes swaps of distinct full-width values observable.

// File: rtl/regxq_pkg.sv
package regxq_pkg;

    localparam int IW     = 16;
    localparam int FLD_W  = 3;
    localparam int CYC_W  = 4;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_EXCH  = 3'd1,
        S_QUICK = 3'd2,
        S_ADDR  = 3'd3,
        S_ILL   = 3'd4
    } state_t;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_EXCH  = 2'd1,
        CLS_QUICK = 2'd2,
        CLS_ADDR  = 2'd3
    } cls_t;

    typedef enum logic [1:0] {
        PAIR_DD  = 2'd0,
        PAIR_AA  = 2'd1,
        PAIR_DA  = 2'd2,
        PAIR_BAD = 2'd3
    } pair_t;

    localparam logic [CYC_W-1:0] COST_EXCH  = CYC_W'(6);
    localparam logic [CYC_W-1:0] COST_QUICK = CYC_W'(4);

endpackage

// File: rtl/regxq_decode.sv
module regxq_decode
    import regxq_pkg::*;
(
    input  logic [IW-1:0]    word,
    output cls_t             cls,
    output pair_t            pair,
    output logic             ea_mode_ok,
    output logic [CYC_W-1:0] cost
);
    logic [4:0] xop;
    logic [2:0] mode;
    logic [2:0] sub;

    assign xop  = word[7:3];
    assign mode = word[5:3];
    assign sub  = word[2:0];

    always_comb begin
        cls = CLS_NONE;
        if (word[15:12] == 4'b1100 && word[8])
            cls = CLS_EXCH;
        else if (word[15:12] == 4'b0111 && !word[8])
            cls = CLS_QUICK;
        else if (word[15:12] == 4'b0100 && word[8:6] == 3'b111)
            cls = CLS_ADDR;
    end

    always_comb begin
        unique case (xop)
            5'b01000: pair = PAIR_DD;
            5'b01001: pair = PAIR_AA;
            5'b10001: pair = PAIR_DA;
            default:  pair = PAIR_BAD;
        endcase
    end

    always_comb begin
        ea_mode_ok = 1'b1;
        cost       = '0;
        unique case (mode)
            3'b010: cost = CYC_W'(4);
            3'b101: cost = CYC_W'(8);
            3'b110: cost = CYC_W'(12);
            3'b111: begin
                unique case (sub)
                    3'b000, 3'b010: cost = CYC_W'(8);
                    3'b001, 3'b011: cost = CYC_W'(12);
                    default:        ea_mode_ok = 1'b0;
                endcase
            end
            default: ea_mode_ok = 1'b0;
        endcase
        if (cls == CLS_EXCH)
            cost = COST_EXCH;
        else if (cls == CLS_QUICK)
            cost = COST_QUICK;
    end

endmodule

// File: rtl/regxq_regfile.sv
module regxq_regfile #(
    parameter int DATA_W = 32,
    parameter int NREG   = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we0,
    input  logic              bank0,
    input  logic [IDX_W-1:0]  idx0,
    input  logic [DATA_W-1:0] wd0,
    input  logic              we1,
    input  logic              bank1,
    input  logic [IDX_W-1:0]  idx1,
    input  logic [DATA_W-1:0] wd1,
    input  logic              xa_bank,
    input  logic [IDX_W-1:0]  xa_idx,
    output logic [DATA_W-1:0] xa_data,
    input  logic              xb_bank,
    input  logic [IDX_W-1:0]  xb_idx,
    output logic [DATA_W-1:0] xb_data,
    input  logic [IDX_W-1:0]  pd_idx,
    output logic [DATA_W-1:0] pd_data,
    input  logic [IDX_W-1:0]  pa_idx,
    output logic [DATA_W-1:0] pa_data
);
    logic [DATA_W-1:0] dbank [NREG];
    logic [DATA_W-1:0] abank [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dbank[g] <= '0;
            end else if (we1 && !bank1 && idx1 == IDX_W'(g)) begin
                dbank[g] <= wd1;
            end else if (we0 && !bank0 && idx0 == IDX_W'(g)) begin
                dbank[g] <= wd0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                abank[g] <= '0;
            end else if (we1 && bank1 && idx1 == IDX_W'(g)) begin
                abank[g] <= wd1;
            end else if (we0 && bank0 && idx0 == IDX_W'(g)) begin
                abank[g] <= wd0;
            end
        end
    end

    assign xa_data = xa_bank ? abank[xa_idx] : dbank[xa_idx];
    assign xb_data = xb_bank ? abank[xb_idx] : dbank[xb_idx];
    assign pd_data = dbank[pd_idx];
    assign pa_data = abank[pa_idx];

endmodule

// File: rtl/regxq_unit.sv
module regxq_unit
    import regxq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NREG   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_vld,
    input  logic [15:0]       instr,
    input  logic [DATA_W-1:0] ea_in,
    output logic              ready,
    input  logic [2:0]        rd_sel_d,
    output logic [DATA_W-1:0] rd_data_d,
    input  logic [2:0]        rd_sel_a,
    output logic [DATA_W-1:0] rd_data_a,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic [3:0]        cyc_cost,
    output logic              done,
    output logic              illegal
);
    localparam int IMM_W = 8;
    localparam int EXT_W = DATA_W - IMM_W;

    state_t            state_q, state_d;
    cls_t              dec_cls;
    pair_t             dec_pair;
    logic              dec_ea_ok;
    logic [CYC_W-1:0]  dec_cost;

    logic [IW-1:0]     word_q;
    logic [DATA_W-1:0] ea_q;
    pair_t             pair_q;
    logic [CYC_W-1:0]  cost_q;

    logic              we0, we1, bank0, bank1;
    logic [FLD_W-1:0]  idx0, idx1;
    logic [DATA_W-1:0] wd0, wd1;
    logic              xa_bank, xb_bank;
    logic [DATA_W-1:0] xa_data, xb_data;
    logic [DATA_W-1:0] quick_val;
    logic              accept;

    regxq_decode u_decode (
        .word       (instr),
        .cls        (dec_cls),
        .pair       (dec_pair),
        .ea_mode_ok (dec_ea_ok),
        .cost       (dec_cost)
    );

    assign ready  = (state_q == S_IDLE);
    assign accept = ready && instr_vld;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (instr_vld) begin
                    unique case (dec_cls)
                        CLS_EXCH:  state_d = (dec_pair == PAIR_BAD) ? S_ILL : S_EXCH;
                        CLS_QUICK: state_d = S_QUICK;
                        CLS_ADDR:  state_d = dec_ea_ok ? S_ADDR : S_ILL;
                        default:   state_d = S_IDLE;
                    endcase
                end
            end
            S_EXCH, S_QUICK, S_ADDR, S_ILL: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // operand capture on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            ea_q   <= '0;
            pair_q <= PAIR_DD;
            cost_q <= '0;
        end else if (accept) begin
            word_q <= instr;
            ea_q   <= ea_in;
            pair_q <= dec_pair;
            cost_q <= dec_cost;
        end
    end

    assign quick_val = {{EXT_W{word_q[IMM_W-1]}}, word_q[IMM_W-1:0]};
    assign xa_bank   = (pair_q == PAIR_AA);
    assign xb_bank   = (pair_q != PAIR_DD);

    // register-file write ports per state
    always_comb begin
        we0   = 1'b0;
        we1   = 1'b0;
        bank0 = 1'b0;
        bank1 = 1'b0;
        idx0  = word_q[11:9];
        idx1  = word_q[2:0];
        wd0   = '0;
        wd1   = '0;
        unique case (state_q)
            S_EXCH: begin
                we0   = 1'b1;
                bank0 = xa_bank;
                wd0   = xb_data;
                we1   = 1'b1;
                bank1 = xb_bank;
                wd1   = xa_data;
            end
            S_QUICK: begin
                we0 = 1'b1;
                wd0 = quick_val;
            end
            S_ADDR: begin
                we0   = 1'b1;
                bank0 = 1'b1;
                wd0   = ea_q;
            end
            default: ;
        endcase
    end

    regxq_regfile #(
        .DATA_W (DATA_W),
        .NREG   (NREG),
        .IDX_W  (FLD_W)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .we0     (we0),
        .bank0   (bank0),
        .idx0    (idx0),
        .wd0     (wd0),
        .we1     (we1),
        .bank1   (bank1),
        .idx1    (idx1),
        .wd1     (wd1),
        .xa_bank (xa_bank),
        .xa_idx  (word_q[11:9]),
        .xa_data (xa_data),
        .xb_bank (xb_bank),
        .xb_idx  (word_q[2:0]),
        .xb_data (xb_data),
        .pd_idx  (rd_sel_d),
        .pd_data (rd_data_d),
        .pa_idx  (rd_sel_a),
        .pa_data (rd_data_a)
    );

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            illegal  <= 1'b0;
            cyc_cost <= '0;
            flag_n   <= 1'b0;
            flag_z   <= 1'b0;
            flag_v   <= 1'b0;
            flag_c   <= 1'b0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            unique case (state_q)
                S_EXCH, S_ADDR: begin
                    done     <= 1'b1;
                    cyc_cost <= cost_q;
                end
                S_QUICK: begin
                    done     <= 1'b1;
                    cyc_cost <= cost_q;
                    flag_n   <= quick_val[DATA_W-1];
                    flag_z   <= (quick_val == '0);
                    flag_v   <= 1'b0;
                    flag_c   <= 1'b0;
                end
                S_ILL: begin
                    illegal  <= 1'b1;
                    cyc_cost <= '0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/regxq_checker.sv
module regxq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_vld,
    input logic [15:0] instr,
    input logic        ready,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_v,
    input logic        flag_c,
    input logic [3:0]  cyc_cost,
    input logic        done,
    input logic        illegal
);
    logic take, is_quick, is_exch, is_addr;

    assign take     = ready && instr_vld;
    assign is_quick = instr[15:12] == 4'b0111 && !instr[8];
    assign is_exch  = instr[15:12] == 4'b1100 && instr[8];
    assign is_addr  = instr[15:12] == 4'b0100 && instr[8:6] == 3'b111;

    assert_busy_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ready);

    assert_quick_cost_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_quick) |=> ##1 (done && cyc_cost == 4'd4));

    assert_quick_vc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_quick) |=> ##1 (!flag_v && !flag_c));

    assert_illegal_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal);

    assert_illegal_not_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(illegal && done));

    assert_exch_flags_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (is_exch || is_addr)) |=> ##1 $stable({flag_n, flag_z, flag_v, flag_c}));

    assert_other_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !is_quick && !is_exch && !is_addr) |=> (ready && !done && !illegal));

endmodule

bind regxq_unit regxq_checker u_regxq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_vld (instr_vld),
    .instr     (instr),
    .ready     (ready),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_v    (flag_v),
    .flag_c    (flag_c),
    .cyc_cost  (cyc_cost),
    .done      (done),
    .illegal   (illegal)
);

// File: tb/regxq_unit_bench.sv
module regxq_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_vld = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] ea_in = '0;
    logic        ready;
    logic [2:0]  rd_sel_d = '0;
    logic [31:0] rd_data_d;
    logic [2:0]  rd_sel_a = '0;
    logic [31:0] rd_data_a;
    logic        flag_n, flag_z, flag_v, flag_c;
    logic [3:0]  cyc_cost;
    logic        done, illegal;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [31:0] md [8];
    logic [31:0] ma [8];
    logic        mn = 1'b0, mz = 1'b0;
    logic [3:0]  mcost = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regxq_unit u_regxq_unit (
        .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr(instr), .ea_in(ea_in),
        .ready(ready), .rd_sel_d(rd_sel_d), .rd_data_d(rd_data_d),
        .rd_sel_a(rd_sel_a), .rd_data_a(rd_data_a),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .cyc_cost(cyc_cost), .done(done), .illegal(illegal)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_sel_d = 3'(i);
            rd_sel_a = 3'(i);
            #1;
            chk(req, $sformatf("D%0d", i), rd_data_d, md[i]);
            chk(req, $sformatf("A%0d", i), rd_data_a, ma[i]);
        end
    endtask

    task automatic chk_flags(input string req);
        chk(req, "flag_n", 32'(flag_n), 32'(mn));
        chk(req, "flag_z", 32'(flag_z), 32'(mz));
        chk(req, "flag_v", 32'(flag_v), 32'd0);
        chk(req, "flag_c", 32'(flag_c), 32'd0);
    endtask

    // kind: 0 dropped, 1 quick, 2 exchange, 3 address load, 4 illegal
    function automatic int kind_of(input logic [15:0] w);
        if (w[15:12] == 4'b0111 && !w[8]) return 1;
        if (w[15:12] == 4'b1100 && w[8])
            return (w[7:3] == 5'b01000 || w[7:3] == 5'b01001 || w[7:3] == 5'b10001) ? 2 : 4;
        if (w[15:12] == 4'b0100 && w[8:6] == 3'b111) begin
            if (w[5:3] == 3'b010 || w[5:3] == 3'b101 || w[5:3] == 3'b110) return 3;
            if (w[5:3] == 3'b111 && w[2:0] <= 3'd3) return 3;
            return 4;
        end
        return 0;
    endfunction

    function automatic logic [3:0] ea_cost(input logic [15:0] w);
        case (w[5:3])
            3'b010: return 4'd4;
            3'b101: return 4'd8;
            3'b110: return 4'd12;
            default: return (w[0]) ? 4'd12 : 4'd8;
        endcase
    endfunction

    task automatic model_apply(input logic [15:0] w, input logic [31:0] ea, input int k);
        logic [31:0] t;
        int x, y;
        x = int'(w[11:9]);
        y = int'(w[2:0]);
        case (k)
            1: begin
                md[x] = 32'(signed'(w[7:0]));
                mn = md[x][31];
                mz = (md[x] == 0);
                mcost = 4'd4;
            end
            2: begin
                if (w[7:3] == 5'b01000) begin t = md[x]; md[x] = md[y]; md[y] = t; end
                else if (w[7:3] == 5'b01001) begin t = ma[x]; ma[x] = ma[y]; ma[y] = t; end
                else begin t = md[x]; md[x] = ma[y]; ma[y] = t; end
                mcost = 4'd6;
            end
            3: begin
                ma[x] = ea;
                mcost = ea_cost(w);
            end
            4: mcost = 4'd0;
            default: ;
        endcase
    endtask

    task automatic run(input string req, input logic [15:0] w, input logic [31:0] ea);
        int k;
        k = kind_of(w);
        @(negedge clk);
        chk("R2", "ready before issue", 32'(ready), 32'd1);
        instr_vld = 1'b1;
        instr = w;
        ea_in = ea;
        @(negedge clk);
        instr_vld = 1'b0;
        chk(req, "ready after accept", 32'(ready), (k == 0) ? 32'd1 : 32'd0);
        chk(req, "done early", 32'(done), 32'd0);
        @(negedge clk);
        model_apply(w, ea, k);
        chk(req, "done", 32'(done), (k >= 1 && k <= 3) ? 32'd1 : 32'd0);
        chk(req, "illegal", 32'(illegal), (k == 4) ? 32'd1 : 32'd0);
        chk(req, "cyc_cost", 32'(cyc_cost), 32'(mcost));
        chk(req, "ready", 32'(ready), 32'd1);
        chk_flags(req);
        chk_regs(req);
    endtask

    function automatic logic [15:0] q_op(input int r, input logic [7:0] imm);
        return {4'b0111, 3'(r), 1'b0, imm};
    endfunction
    function automatic logic [15:0] x_op(input int rx, input logic [4:0] op, input int ry);
        return {4'b1100, 3'(rx), 1'b1, op, 3'(ry)};
    endfunction
    function automatic logic [15:0] a_op(input int r, input logic [2:0] mode, input logic [2:0] sub);
        return {4'b0100, 3'(r), 3'b111, mode, sub};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin md[i] = '0; ma[i] = '0; end
        #(CLK_PERIOD * 2 + 2);
        // R1: reset state, sampled while still in reset and just after release
        chk("R1", "ready", 32'(ready), 32'd1);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "illegal", 32'(illegal), 32'd0);
        chk("R1", "cyc_cost", 32'(cyc_cost), 32'd0);
        rst_n = 1'b1;
        chk_flags("R1");
        chk_regs("R1");

        // R3 / R4: quick load, sign extension and flags
        run("R3", q_op(3, 8'h05), '0);
        run("R4", q_op(0, 8'hFF), '0);
        run("R4", q_op(1, 8'h80), '0);
        run("R3", q_op(2, 8'h7F), '0);
        run("R4", q_op(7, 8'h00), '0);

        // R7: address load over all legal modes, R9 flags kept (Z set above)
        run("R7", a_op(0, 3'b010, 3'd5), 32'hDEAD_BEEF);
        run("R7", a_op(1, 3'b101, 3'd0), 32'h1234_5678);
        run("R7", a_op(2, 3'b110, 3'd3), 32'h8000_0000);
        run("R7", a_op(3, 3'b111, 3'd0), 32'h0000_FFFE);
        run("R7", a_op(4, 3'b111, 3'd1), 32'hCAFE_F00D);
        run("R7", a_op(5, 3'b111, 3'd2), 32'h0BAD_CAFE);
        run("R9", a_op(6, 3'b111, 3'd3), 32'h7FFF_FFFF);

        // R5: exchanges in all three pairings
        run("R5", x_op(3, 5'b01000, 0), '0);
        run("R5", x_op(0, 5'b01001, 1), '0);
        run("R5", x_op(2, 5'b10001, 4), '0);
        run("R9", x_op(5, 5'b10001, 6), '0);
        // R6: self swaps
        run("R6", x_op(2, 5'b01000, 2), '0);
        run("R6", x_op(6, 5'b01001, 6), '0);
        run("R6", x_op(5, 5'b10001, 5), '0);

        // R8: rejected forms
        run("R8", x_op(1, 5'b01010, 2), '0);
        run("R8", x_op(3, 5'b00000, 4), '0);
        run("R8", a_op(7, 3'b000, 3'd1), 32'hFFFF_FFFF);
        run("R8", a_op(7, 3'b111, 3'd4), 32'hFFFF_FFFF);
        run("R8", a_op(7, 3'b011, 3'd0), 32'hFFFF_FFFF);

        // cost set non-zero again, then R10 dropped words keep it
        run("R3", q_op(4, 8'h81), '0);
        run("R10", 16'h0000, 32'h1111_1111);
        run("R10", {4'b0111, 3'd4, 1'b1, 8'h00}, '0);
        run("R10", {4'b0100, 3'd1, 3'b110, 3'b010, 3'd0}, 32'h2222_2222);
        run("R10", {4'b1100, 3'd1, 1'b0, 5'b01000, 3'd2}, '0);

        // R2: word offered while busy is ignored
        @(negedge clk);
        instr_vld = 1'b1;
        instr = q_op(1, 8'h03);
        @(negedge clk);
        instr = q_op(5, 8'h09);
        chk("R2", "ready busy", 32'(ready), 32'd0);
        @(negedge clk);
        instr_vld = 1'b0;
        model_apply(q_op(1, 8'h03), '0, 1);
        chk("R2", "done", 32'(done), 32'd1);
        @(negedge clk);
        chk("R2", "single done", 32'(done), 32'd0);
        chk("R2", "cyc_cost held", 32'(cyc_cost), 32'(mcost));
        chk_flags("R2");
        chk_regs("R2");

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule